// File: doc/BRIEF.md
# Synchronous Burst Memory Bus Responder

This block joins a bus requester and a memory responder over a wide synchronous bus whose timing is fixed in cycles. Nothing on the bus acknowledges anything. A requester raises a start strobe for exactly one clock, with the transfer mode and the word address, and that clock is the address cycle. From then on both sides count cycles. The responder waits out a long first access and then drives the block onto the bus in groups of four words, two words per data clock. It fetches each later group during the transfer of the one before it. The requester never looks at a ready signal. It captures the bus at cycle positions it works out for itself.

A transaction carries one word, a four-word block or a sixteen-word block. Each one ends with a fixed pair of idle clocks. A start that arrives while the responder is busy, including during those idle clocks, is dropped by both sides and raises a one-clock protocol-error pulse. When a transaction ends, the requester reports its total length in cycles.

Top module: `sync_burst_bus`

## Requirements
- R1: During and right after reset, `bus_valid`, `bus_data`, `cap_valid`, `done` and `proto_err` are all zero.
- R2: Mode 2'b01 (four words). Take the address cycle as cycle 0. `bus_valid` is high in cycles 41 and 42 only. Beat b carries word a+2b in bits [31:0] and word a+2b+1 in bits [63:32].
- R3: Modes 2'b10 and 2'b11 (sixteen words). Group k (k = 0..3) is on the bus in cycles 41+4k and 42+4k. Beat index 2k+b carries words a+4k+2b (low half) and a+4k+2b+1 (high half). The bus is idle in every other cycle.
- R4: Mode 2'b00 (single word). `bus_valid` is high in cycle 2 only, with the word at address a in bits [31:0] and zero in bits [63:32].
- R5: The word held at address x is {8'h00, x[15:0], 8'hC3}. Block addresses wrap modulo 2^16.
- R6: `done` pulses in the first cycle after a transaction, including its two idle clocks. In that same cycle `txn_len` gives the total length: 5 for a single word, 45 for a four-word block, 57 for a sixteen-word block.
- R7: A start raised in any cycle from 1 up to the last idle clock of a transaction is ignored, and the bus schedule of the current transaction is left unchanged. `proto_err` is high in the cycle after that start.
- R8: A start in the first cycle after the idle clocks is accepted as a new address cycle, and `proto_err` stays low.
- R9: For every data clock, the requester shows the captured beat one cycle later. `cap_valid` goes high, `cap_data` equals that beat and `cap_idx` gives its beat number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| go | input | 1 | Start strobe; its cycle is the address cycle |
| go_mode | input | 2 | 00 single, 01 four-word, 1x sixteen-word |
| go_addr | input | 16 | Word address, valid with go |
| bus_valid | output | 1 | Responder is driving a data beat |
| bus_data | output | 64 | Data beat, two words |
| cap_valid | output | 1 | Requester captured a beat in the previous cycle |
| cap_data | output | 64 | Captured beat |
| cap_idx | output | 3 | Beat number within the transaction |
| done | output | 1 | Transaction finished |
| txn_len | output | 6 | Total transaction cycles, valid with done |
| proto_err | output | 1 | A start was dropped in the previous cycle |

## Verification
Every scenario places the start strobe at a falling edge, so the next rising edge closes cycle 0. The bench then visits cycles 1 up to the transaction length one by one, at falling edges, and works out what each output should be in each cycle. It expects bus beats at cycle 2 for a single word and at 41+4k and 42+4k for blocks. Captures, `done` and `proto_err` are all expected exactly one cycle after the event that causes them. Dropped starts are injected in cycle 10 and in the last idle cycle, and the full bus schedule is checked again around them.

// File: rtl/sync_burst_bus.sv
module sync_burst_bus #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 16,
  parameter int FIRST_LAT  = 40,
  parameter int NEXT_LAT   = 4,
  parameter int GAP        = 2,
  parameter int SINGLE_LAT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [1:0]           go_mode,
  input  logic [ADDR_W-1:0]    go_addr,
  output logic                 bus_valid,
  output logic [2*DATA_W-1:0]  bus_data,
  output logic                 cap_valid,
  output logic [2*DATA_W-1:0]  cap_data,
  output logic [2:0]           cap_idx,
  output logic                 done,
  output logic [5:0]           txn_len,
  output logic                 proto_err
);
  localparam int BUS_W    = 2 * DATA_W;
  localparam int WPB      = BUS_W / DATA_W;
  localparam int GRP_W    = 4;
  localparam int BEATS    = GRP_W / WPB;
  localparam int MAX_GRPS = 4;
  localparam int LAST_BLK = FIRST_LAT + (MAX_GRPS - 1) * NEXT_LAT + BEATS + GAP;
  localparam int LAST_SGL = SINGLE_LAT + GAP;
  localparam int LAST_MAX = (LAST_BLK > LAST_SGL) ? LAST_BLK : LAST_SGL;
  localparam int CNT_W    = $clog2(LAST_MAX + 2);
  localparam int GW       = $clog2(MAX_GRPS + 1);
  localparam int BW       = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int BUFW     = $clog2(GRP_W);
  localparam int IDX_W    = $clog2(MAX_GRPS * BEATS);
  localparam logic [7:0] TAG = 8'hC3;

  function automatic logic [GW-1:0] ngrp(input logic [1:0] m);
    return m[1] ? GW'(MAX_GRPS) : GW'(1);
  endfunction

  function automatic logic [CNT_W-1:0] last_of(input logic [1:0] m);
    if (m == 2'b00) return CNT_W'(LAST_SGL);
    return CNT_W'(FIRST_LAT + (int'(ngrp(m)) - 1) * NEXT_LAT + BEATS + GAP);
  endfunction

  function automatic logic [DATA_W-1:0] word_at(input logic [ADDR_W-1:0] a);
    return DATA_W'({a, TAG});
  endfunction

  // responder
  logic              rs_busy, rs_send;
  logic [CNT_W-1:0]  rs_cnt, rs_tmr;
  logic [1:0]        rs_mode;
  logic [ADDR_W-1:0] rs_addr;
  logic [GW-1:0]     rs_fg;
  logic [BW-1:0]     rs_beat;
  logic [DATA_W-1:0] rs_buf [GRP_W];
  logic [BW-1:0]     last_beat;

  assign last_beat = (rs_mode == 2'b00) ? '0 : BW'(BEATS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_busy   <= 1'b0;
      rs_send   <= 1'b0;
      rs_cnt    <= '0;
      rs_tmr    <= '0;
      rs_mode   <= '0;
      rs_addr   <= '0;
      rs_fg     <= '0;
      rs_beat   <= '0;
      proto_err <= 1'b0;
      for (int j = 0; j < GRP_W; j++) rs_buf[j] <= '0;
    end else begin
      proto_err <= go && rs_busy;
      if (!rs_busy) begin
        if (go) begin
          rs_busy <= 1'b1;
          rs_cnt  <= CNT_W'(1);
          rs_mode <= go_mode;
          rs_addr <= go_addr;
          rs_fg   <= '0;
          rs_send <= 1'b0;
          rs_tmr  <= (go_mode == 2'b00) ? CNT_W'(SINGLE_LAT - 2) : CNT_W'(FIRST_LAT - 1);
        end
      end else begin
        rs_cnt <= rs_cnt + 1'b1;
        if (rs_cnt == last_of(rs_mode)) rs_busy <= 1'b0;
        if (rs_send) begin
          if (rs_beat == last_beat) rs_send <= 1'b0;
          rs_beat <= rs_beat + 1'b1;
        end
        if (rs_fg < ngrp(rs_mode)) begin
          if (rs_tmr == '0) begin
            for (int j = 0; j < GRP_W; j++)
              rs_buf[j] <= word_at(rs_addr + ADDR_W'(rs_fg) * ADDR_W'(GRP_W) + ADDR_W'(j));
            rs_fg   <= rs_fg + 1'b1;
            rs_send <= 1'b1;
            rs_beat <= '0;
            rs_tmr  <= CNT_W'(NEXT_LAT - 1);
          end else begin
            rs_tmr <= rs_tmr - 1'b1;
          end
        end
      end
    end
  end

  assign bus_valid = rs_send;

  always_comb begin
    bus_data = '0;
    if (rs_send)
      for (int w = 0; w < WPB; w++)
        if (rs_mode != 2'b00 || w == 0)
          bus_data[w*DATA_W +: DATA_W] = rs_buf[BUFW'(int'(rs_beat) * WPB + w)];
  end

  // requester
  logic              rq_busy, rq_hit;
  logic [CNT_W-1:0]  rq_cnt, rel;
  logic [1:0]        rq_mode;
  logic [IDX_W-1:0]  rq_idx;

  assign rel = rq_cnt - CNT_W'(FIRST_LAT + 1);

  always_comb begin
    rq_hit = 1'b0;
    rq_idx = '0;
    if (rq_mode == 2'b00) begin
      rq_hit = (rq_cnt == CNT_W'(SINGLE_LAT));
    end else if (rq_cnt >= CNT_W'(FIRST_LAT + 1)) begin
      if ((rel % CNT_W'(NEXT_LAT)) < CNT_W'(BEATS) &&
          (rel / CNT_W'(NEXT_LAT)) < CNT_W'(ngrp(rq_mode))) begin
        rq_hit = 1'b1;
        rq_idx = IDX_W'((rel / CNT_W'(NEXT_LAT)) * CNT_W'(BEATS) + rel % CNT_W'(NEXT_LAT));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_busy   <= 1'b0;
      rq_cnt    <= '0;
      rq_mode   <= '0;
      cap_valid <= 1'b0;
      cap_data  <= '0;
      cap_idx   <= '0;
      done      <= 1'b0;
      txn_len   <= '0;
    end else begin
      cap_valid <= 1'b0;
      done      <= 1'b0;
      if (!rq_busy) begin
        if (go) begin
          rq_busy <= 1'b1;
          rq_cnt  <= CNT_W'(1);
          rq_mode <= go_mode;
        end
      end else begin
        rq_cnt <= rq_cnt + 1'b1;
        if (rq_hit) begin
          cap_valid <= 1'b1;
          cap_data  <= bus_data;
          cap_idx   <= 3'(rq_idx);
        end
        if (rq_cnt == last_of(rq_mode)) begin
          rq_busy <= 1'b0;
          done    <= 1'b1;
          txn_len <= 6'(rq_cnt + 1'b1);
        end
      end
    end
  end

  p_valid_in_txn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> rs_busy);
  p_err_on_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && rs_busy) |=> proto_err);
  p_no_err_when_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !rs_busy) |=> !proto_err);
  p_sample_on_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_busy && rq_hit) |-> bus_valid);
  p_sides_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rs_busy == rq_busy);
  p_len_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(txn_len) == LAST_SGL + 1 || int'(txn_len) == LAST_BLK + 1 ||
              int'(txn_len) == FIRST_LAT + BEATS + GAP + 1));
endmodule

// File: tb/sim_sync_burst_bus.sv
module sim_sync_burst_bus;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [1:0]  go_mode = '0;
  logic [15:0] go_addr = '0;
  logic        bus_valid, cap_valid, done, proto_err;
  logic [63:0] bus_data, cap_data;
  logic [2:0]  cap_idx;
  logic [5:0]  txn_len;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sync_burst_bus u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .go_mode(go_mode), .go_addr(go_addr),
    .bus_valid(bus_valid), .bus_data(bus_data), .cap_valid(cap_valid),
    .cap_data(cap_data), .cap_idx(cap_idx), .done(done), .txn_len(txn_len),
    .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] w_at(input logic [15:0] a, input int off);
    logic [15:0] x;
    x = a + 16'(off);
    return {8'h00, x, 8'hC3};
  endfunction

  function automatic int beat_at(input logic [1:0] m, input int n);
    int ng, r;
    if (m == 2'b00) return (n == 2) ? 0 : -1;
    ng = m[1] ? 4 : 1;
    if (n < 41) return -1;
    r = n - 41;
    if (r % 4 < 2 && r / 4 < ng) return (r / 4) * 2 + r % 4;
    return -1;
  endfunction

  function automatic logic [63:0] beat_data(input logic [1:0] m, input logic [15:0] a, input int idx);
    if (m == 2'b00) return {32'h0, w_at(a, 0)};
    return {w_at(a, 2 * idx + 1), w_at(a, 2 * idx)};
  endfunction

  // called at a falling edge with the bus free; inj > 0 raises a stray start in that cycle
  task automatic run_txn(input logic [1:0] m, input logic [15:0] a, input int total,
                         input int inj, input string tag);
    go = 1'b1; go_mode = m; go_addr = a;
    @(posedge clk);
    for (int n = 1; n <= total; n++) begin
      int bi, pi;
      @(negedge clk);
      go = (n == inj);
      if (n == inj) begin go_mode = 2'b10; go_addr = a + 16'h0100; end
      bi = beat_at(m, n);
      pi = beat_at(m, n - 1);
      chk(bus_valid == (bi >= 0), {tag, " bus_valid schedule"}, 64'(bus_valid), 64'(bi >= 0));
      if (bi >= 0)
        chk(bus_data == beat_data(m, a, bi), {tag, " R5 beat data"}, bus_data, beat_data(m, a, bi));
      chk(cap_valid == (pi >= 0), "R9 cap_valid", 64'(cap_valid), 64'(pi >= 0));
      if (pi >= 0) begin
        chk(cap_data == beat_data(m, a, pi), "R9 cap_data", cap_data, beat_data(m, a, pi));
        chk(cap_idx == 3'(pi), "R9 cap_idx", 64'(cap_idx), 64'(pi));
      end
      chk(done == (n == total), "R6 done timing", 64'(done), 64'(n == total));
      if (n == total) chk(txn_len == 6'(total), "R6 txn_len", 64'(txn_len), 64'(total));
      chk(proto_err == (inj > 0 && n == inj + 1), "R7 proto_err", 64'(proto_err),
          64'(inj > 0 && n == inj + 1));
    end
    go = 1'b0;
  endtask

  task automatic quiet(input int cycles, input string tag);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(!bus_valid && !cap_valid && !done && !proto_err, {tag, " bus quiet"},
          {60'h0, bus_valid, cap_valid, done, proto_err}, 64'h0);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(!bus_valid && bus_data == '0 && !cap_valid && !done && !proto_err, "R1 reset outputs",
        {bus_data[59:0], bus_valid, cap_valid, done, proto_err}, 64'h0);
    rst_n = 1'b1;
    quiet(2, "R1");
  endtask

  task automatic t_single;
    run_txn(2'b00, 16'h1234, 5, 0, "R4");
    quiet(2, "R4");
  endtask

  task automatic t_block4;
    run_txn(2'b01, 16'h0040, 45, 0, "R2");
    quiet(2, "R2");
  endtask

  task automatic t_block16_wrap;
    run_txn(2'b10, 16'hFFFA, 57, 0, "R3");
    run_txn(2'b11, 16'h0200, 57, 0, "R3");
    quiet(2, "R3");
  endtask

  task automatic t_collide;
    run_txn(2'b01, 16'h0300, 45, 10, "R7");
    run_txn(2'b01, 16'h0310, 45, 44, "R7");
    quiet(2, "R7");
  endtask

  task automatic t_back2back;
    run_txn(2'b01, 16'h0500, 45, 0, "R8");
    run_txn(2'b00, 16'h0600, 5, 0, "R8");
    run_txn(2'b10, 16'h0700, 57, 0, "R8");
    quiet(3, "R8");
  endtask

  initial begin
    t_reset();
    t_single();
    t_block4();
    t_block16_wrap();
    t_collide();
    t_back2back();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule